// File: doc/BRIEF.md
# Chained Dual-Channel Timebase Counter

This block builds a wide free-running timebase out of two narrow counter channels. The low channel advances on a one-cycle enable pulse from a free-running prescaler. The prescaler divides the system clock by 2, 8, 32 or 128. The low channel drives a square-wave output, set by one compare value and cleared by another. A chaining selector lets the high channel advance on each rising edge of that waveform. With the default compare values, the pair `{high, low}` counts as one monotonic double-width value.

Software controls the block through a small register port. It picks the divisor and the chaining option. It enables or disables each channel with separate command bits. It can zero both channels in the same clock edge with a sync command. A read of the low count copies the high count into a shadow register. A later read of the shadow therefore returns the high half that belongs with that low value, even if the high channel has moved on since.

Top module: `chain_timebase`

## Requirements
- R1: After reset, both counts, the shadow and `waveOut` are 0. Both channels are disabled, the divisor index is 0 and chaining is off. The set compare is 0 and the clear compare is 2^(CNT_W-1).
- R2: A write to address 1 stores the divisor index from `regWdata[1:0]`. Counting from a sync, the low channel advances once every 2^(1+2*index) cycles. After the k-th edge following the sync edge, the low count equals floor(k/div) mod 2^CNT_W.
- R3: The low channel counts up through its full range and wraps to 0. It never reloads on a compare, and between edges it changes only by +1 or to 0.
- R4: When the low count reaches the set compare (address 4), `waveOut` goes to 1. When the low count reaches the clear compare (address 5), `waveOut` goes to 0. The set compare wins a tie. With the default compares, `waveOut` is 0 until the first wrap, then 1 while low < 2^(CNT_W-1) and 0 otherwise.
- R5: The high channel advances by one on a rising edge of the waveform when chaining (address 2, bit 0 = 1) and the high channel are both enabled. With the default compares, this happens in the same edge where low wraps to 0, so the high count equals floor(k/(div*2^CNT_W)).
- R6: With chaining off, the high count holds.
- R7: Writes to address 3 are channel commands. Bit 0 enables the low channel and bit 1 disables it. Bit 2 enables the high channel and bit 3 disables it. A disable bit wins over its enable bit. A disabled channel holds its count.
- R8: A write to address 0 with bit 0 set zeroes both counts, the prescaler phase and the waveform in that edge.
- R9: A read strobe drives `regRdata` one cycle later. Address 0 returns the low count, address 1 the high count and address 2 the shadow. A read of address 0 copies the current high count into the shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | CNT_W | Write data |
| regRdata | output | CNT_W | Read data, valid one cycle after the strobe |
| waveOut | output | 1 | Low-channel compare waveform |

## Verification
The bench builds the block with CNT_W = 8. A full low-channel wrap then takes at most 256 × 128 cycles, so a run can reach several wraps at the fastest divisor and a wrap at each of the other three divisors. This puts within reach the shadow coherence across a carry, the waveform duty pattern before and after the first wrap, and a sync issued while the high count is non-zero. The same settings also make room for the hold checks with chaining off, with the high channel disabled, and with the low channel frozen partway through its range.

// File: rtl/chain_timebase_pkg.sv
package chain_timebase_pkg;
  localparam int ADDR_W = 3;
  localparam int PRE_W = 7;

  localparam logic [ADDR_W-1:0] A_SYNC   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV    = 3'd1;
  localparam logic [ADDR_W-1:0] A_CHAIN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd3;
  localparam logic [ADDR_W-1:0] A_SETCMP = 3'd4;
  localparam logic [ADDR_W-1:0] A_CLRCMP = 3'd5;

  localparam logic [ADDR_W-1:0] R_LOW    = 3'd0;
  localparam logic [ADDR_W-1:0] R_HIGH   = 3'd1;
  localparam logic [ADDR_W-1:0] R_SHADOW = 3'd2;

  typedef struct packed {
    logic       syncPulse;
    logic       lowEn;
    logic       highEn;
    logic       chainSel;
    logic [1:0] divIdx;
    logic       rdLow;
    logic       rdHigh;
    logic       rdShadow;
  } strb_t;

  function automatic logic [PRE_W-1:0] divMask(input logic [1:0] idx);
    case (idx)
      2'd0:    return 7'h01;
      2'd1:    return 7'h07;
      2'd2:    return 7'h1F;
      default: return 7'h7F;
    endcase
  endfunction
endpackage

// File: rtl/chain_timebase_ctrl.sv
module chain_timebase_ctrl
  import chain_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output strb_t             strb,
  output logic [CNT_W-1:0]  setCmp,
  output logic [CNT_W-1:0]  clrCmp
);
  localparam logic [CNT_W-1:0] HALF = {1'b1, {(CNT_W-1){1'b0}}};

  logic       lowEnQ, highEnQ, chainQ;
  logic [1:0] divQ;
  logic [CNT_W-1:0] setQ, clrQ;

  logic wrCmd;
  assign wrCmd = regWe && (regAddr == A_CMD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowEnQ  <= 1'b0;
      highEnQ <= 1'b0;
      chainQ  <= 1'b0;
      divQ    <= 2'd0;
      setQ    <= '0;
      clrQ    <= HALF;
    end else begin
      if (regWe && regAddr == A_DIV)    divQ   <= regWdata[1:0];
      if (regWe && regAddr == A_CHAIN)  chainQ <= regWdata[0];
      if (regWe && regAddr == A_SETCMP) setQ   <= regWdata;
      if (regWe && regAddr == A_CLRCMP) clrQ   <= regWdata;
      if (wrCmd) begin
        if (regWdata[1])      lowEnQ  <= 1'b0;
        else if (regWdata[0]) lowEnQ  <= 1'b1;
        if (regWdata[3])      highEnQ <= 1'b0;
        else if (regWdata[2]) highEnQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strb.syncPulse = regWe && (regAddr == A_SYNC) && regWdata[0];
    strb.lowEn     = lowEnQ;
    strb.highEn    = highEnQ;
    strb.chainSel  = chainQ;
    strb.divIdx    = divQ;
    strb.rdLow     = regRe && (regAddr == R_LOW);
    strb.rdHigh    = regRe && (regAddr == R_HIGH);
    strb.rdShadow  = regRe && (regAddr == R_SHADOW);
  end

  assign setCmp = setQ;
  assign clrCmp = clrQ;
endmodule

// File: rtl/chain_timebase_dp.sv
module chain_timebase_dp
  import chain_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strb_t            strb,
  input  logic [CNT_W-1:0] setCmp,
  input  logic [CNT_W-1:0] clrCmp,
  output logic [CNT_W-1:0] lowCnt,
  output logic [CNT_W-1:0] highCnt,
  output logic             waveOut,
  output logic [CNT_W-1:0] regRdata
);
  logic [PRE_W-1:0] prescQ;
  logic [CNT_W-1:0] lowQ, highQ, shadowQ, rdataQ, lowNext;
  logic waveQ, waveNext, tick, step, rise;

  assign tick    = (prescQ & divMask(strb.divIdx)) == divMask(strb.divIdx);
  assign step    = strb.lowEn && tick;
  assign lowNext = lowQ + 1'b1;

  always_comb begin
    waveNext = waveQ;
    if (step) begin
      if (lowNext == setCmp)      waveNext = 1'b1;
      else if (lowNext == clrCmp) waveNext = 1'b0;
    end
  end

  assign rise = waveNext && !waveQ;

  always_ff @(posedge clk) begin
    if (!rstN || strb.syncPulse) begin
      prescQ <= '0;
      lowQ   <= '0;
      highQ  <= '0;
      waveQ  <= 1'b0;
    end else begin
      prescQ <= prescQ + 1'b1;
      if (step) lowQ <= lowNext;
      waveQ <= waveNext;
      if (rise && strb.highEn && strb.chainSel) highQ <= highQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
      rdataQ  <= '0;
    end else begin
      if (strb.rdLow) shadowQ <= highQ;
      if (strb.rdLow)         rdataQ <= lowQ;
      else if (strb.rdHigh)   rdataQ <= highQ;
      else if (strb.rdShadow) rdataQ <= shadowQ;
      else                    rdataQ <= '0;
    end
  end

  assign lowCnt   = lowQ;
  assign highCnt  = highQ;
  assign waveOut  = waveQ;
  assign regRdata = rdataQ;
endmodule

// File: rtl/chain_timebase.sv
module chain_timebase
  import chain_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic             regRe,
  input  logic [2:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  output logic             waveOut
);
  strb_t strb;
  logic [CNT_W-1:0] setCmp, clrCmp, lowCnt, highCnt;

  chain_timebase_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata),
    .strb(strb), .setCmp(setCmp), .clrCmp(clrCmp)
  );

  chain_timebase_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .setCmp(setCmp), .clrCmp(clrCmp),
    .lowCnt(lowCnt), .highCnt(highCnt),
    .waveOut(waveOut), .regRdata(regRdata)
  );
endmodule

// File: rtl/chain_timebase_chk.sv
module chain_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic             regRe,
  input logic [2:0]       regAddr,
  input logic [CNT_W-1:0] regWdata,
  input logic [CNT_W-1:0] regRdata,
  input logic [CNT_W-1:0] lowCnt,
  input logic [CNT_W-1:0] highCnt,
  input logic             lowEn,
  input logic             chainSel
);
  logic syncWr;
  assign syncWr = regWe && (regAddr == 3'd0) && regWdata[0];

  // R8
  sync_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncWr |=> (lowCnt == '0 && highCnt == '0));

  // R3
  low_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncWr |=> (lowCnt == $past(lowCnt) || lowCnt == $past(lowCnt) + 1'b1));

  // R5
  carry_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(highCnt) && !$past(syncWr)) |-> lowCnt == '0);

  // R7
  low_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lowEn && !syncWr) |=> $stable(lowCnt));

  // R6
  chain_off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!chainSel && !syncWr) |=> $stable(highCnt));

  // R9
  high_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == 3'd1) |=> regRdata == $past(highCnt));
endmodule

bind chain_timebase chain_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
  .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
  .lowCnt(lowCnt), .highCnt(highCnt),
  .lowEn(strb.lowEn), .chainSel(strb.chainSel)
);

// File: tb/chain_timebase_tb.sv
module chain_timebase_tb;
  localparam int CW  = 8;
  localparam int MOD = 1 << CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0, regRe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [CW-1:0] regWdata = '0;
  logic [CW-1:0] regRdata;
  logic waveOut;

  int nChecks = 0, nFails = 0;
  int kSince = 0;
  int div = 2;
  bit chained = 1'b1;
  int expQ[$];
  string tagQ[$];
  logic reSeen = 1'b0;

  always #10 clk = ~clk;

  chain_timebase #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .waveOut(waveOut)
  );

  always @(posedge clk) begin
    if (!rstN) kSince <= 0;
    else if (regWe && regAddr == 3'd0 && regWdata[0]) kSince <= 0;
    else kSince <= kSince + 1;
    reSeen <= regRe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (reSeen && expQ.size() > 0) begin
      int e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      chk(int'(regRdata) == (e % MOD), t, int'(regRdata), e % MOD);
    end
  end

  function automatic int expLow(input int k);
    return (k / div) % MOD;
  endfunction

  function automatic int expHigh(input int k);
    return chained ? ((k / (div * MOD)) % MOD) : 0;
  endfunction

  task automatic wr(input logic [2:0] a, input int d);
    regWe = 1'b1; regAddr = a; regWdata = CW'(d);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    regRe = 1'b1; regAddr = a;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic doSync();
    wr(3'd0, 1);
  endtask

  task automatic waitK(input int k);
    while (kSince < k) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(waveOut == 1'b0, "R1 waveOut", int'(waveOut), 0);
    rd(3'd0, 0, "R1 low");
    rd(3'd1, 0, "R1 high");
    rd(3'd2, 0, "R1 shadow");
    // R7 disabled after reset: low holds
    repeat (40) @(negedge clk);
    rd(3'd0, 0, "R7 low disabled at reset");

    // enable both, chain on, div 2
    wr(3'd3, 5);
    wr(3'd2, 1);
    wr(3'd1, 0);
    div = 2; chained = 1'b1;
    doSync();
    // R4 waveform, R3 wrap, R2 div 2
    for (int i = 0; i < 1200; i++) begin
      int k, lo;
      bit w;
      k = kSince;
      lo = expLow(k);
      w = (k >= MOD * div) && (lo < MOD / 2);
      chk(waveOut == w, "R4 default waveform", int'(waveOut), int'(w));
      if (i % 97 == 0) rd(3'd0, lo, "R3 low count across wrap");
      else @(negedge clk);
    end
    rd(3'd1, expHigh(kSince), "R5 high after wraps");

    // R9 shadow coherence
    waitK(3 * MOD * div - 1);
    rd(3'd0, expLow(kSince), "R9 low before carry");
    repeat (5) @(negedge clk);
    rd(3'd2, 2, "R9 shadow coherent");
    rd(3'd1, expHigh(kSince), "R9 live high after carry");

    // R8 sync with high non-zero
    doSync();
    waitK(3);
    rd(3'd1, 0, "R8 high zeroed");
    rd(3'd0, expLow(kSince), "R8 low restarted");

    // R2 other divisors
    for (int idx = 1; idx < 4; idx++) begin
      int tgt;
      wr(3'd1, idx);
      div = 1 << (1 + 2 * idx);
      doSync();
      tgt = div * MOD + 5 * div + 3;
      waitK(tgt);
      rd(3'd0, expLow(kSince), "R2 low at divisor");
      rd(3'd1, expHigh(kSince), "R5 high at divisor");
    end

    // R7 low disable freezes count (div 8)
    wr(3'd1, 1);
    div = 8;
    doSync();
    waitK(700);
    begin
      int frozen;
      frozen = ((kSince + 1) / div) % MOD;
      wr(3'd3, 2);
      repeat (300) @(negedge clk);
      rd(3'd0, frozen, "R7 low frozen");
      repeat (50) @(negedge clk);
      rd(3'd0, frozen, "R7 low still frozen");
    end
    wr(3'd3, 1);

    // R6 chain off: high holds through wraps
    wr(3'd1, 0);
    div = 2;
    doSync();
    wr(3'd2, 0);
    chained = 1'b0;
    waitK(1300);
    rd(3'd1, 0, "R6 high held with chain off");
    rd(3'd0, expLow(kSince), "R6 low keeps counting");

    // R7 high disabled with chain on
    wr(3'd2, 1);
    wr(3'd3, 8);
    doSync();
    waitK(1300);
    rd(3'd1, 0, "R7 high held while disabled");

    // R4 programmed compares
    wr(3'd4, 16);
    wr(3'd5, 32);
    doSync();
    for (int i = 0; i < 600; i++) begin
      int lo;
      bit w;
      lo = expLow(kSince);
      w = (lo >= 16) && (lo < 32);
      chk(waveOut == w, "R4 programmed compares", int'(waveOut), int'(w));
      @(negedge clk);
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule